// File: doc/BRIEF.md
# Multicore IRQ/FIQ Interrupt Router

This block steers interrupt sources onto the IRQ and FIQ lines of a four-core cluster. Each core has four local timer request lines. A companion mailbox block supplies a pending vector with four mailboxes per core. The cluster also has one shared upstream IRQ line and one shared upstream FIQ line. Software programs, for each core, a timer enable word and a mailbox enable word. In each word, bit n sends source n to IRQ and bit n+4 sends it to FIQ. FIQ takes priority when both bits are set. A routing register picks the core that receives the upstream IRQ and, separately, the core that receives the upstream FIQ.

For each core the block derives a 9-bit IRQ source vector and a 9-bit FIQ source vector. Bits 0–3 are the timers, bits 4–7 are the mailboxes and bit 8 is the upstream line. Software can read both vectors. A core's output line is the OR of its vector, registered once. Accesses go through a single-cycle 32-bit word bus. Reads are combinational. Writes take effect at the clock edge.

Top module: `irq_router`

## Requirements
- R1: After reset both routing fields are 0 (core 0), every timer and mailbox enable word reads 0, and every irq_o/fiq_o is low.
- R2: Offset 0x0C holds the upstream IRQ target core in bits [1:0] and the upstream FIQ target core in bits [3:2]. A read returns the same packing, with all other bits zero.
- R3: Timer enable words sit at 0x40+4*core and mailbox enable words at 0x50+4*core. Each keeps only the low 8 bits of a write.
- R4: When timer line n of core c is high, enable bit n+4 set places it in bit n of core c's FIQ source only. Otherwise, enable bit n set places it in bit n of the IRQ source. With neither bit set it appears in neither vector.
- R5: When mailbox j of core c is pending (mailbox input bit 4*c+j), the same enable rule applies using core c's mailbox word, at source bit 4+j.
- R6: A high upstream IRQ sets bit 8 of the IRQ source of the routed core only. A high upstream FIQ sets bit 8 of the FIQ source of its own routed core only.
- R7: IRQ source vectors read at 0x60+4*core and FIQ source vectors at 0x70+4*core. They reflect input levels in the same cycle, with no clock edge needed. Writes to them are ignored.
- R8: irq_o[c] (fiq_o[c]) is high in the cycle after a clock edge at which core c's IRQ (FIQ) source vector was nonzero, and low otherwise.
- R9: Reads at unmapped or non-word-aligned offsets return 0. Writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_irq_i | input | 16 | Local timer lines, bit 4*core+n |
| mbox_pend_i | input | 16 | Mailbox pending levels, bit 4*core+j |
| up_irq_i | input | 1 | Shared upstream IRQ level |
| up_fiq_i | input | 1 | Shared upstream FIQ level |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 4 | Per-core IRQ output |
| fiq_o | output | 4 | Per-core FIQ output |

## Verification
The assertions check four properties on every cycle:
- No timer or mailbox source shows up in a core's IRQ and FIQ vectors at once.
- Exactly one core carries the upstream bit when an upstream line is high, and no core does when it is low.
- Each output equals the OR of its source vector one edge earlier.
- No enable or routing word changes unless a write is decoded to it.

Only the bench scenarios can show the rest:
- the correct values for specific enable patterns;
- the packing of the routing word;
- the masking of writes to 8 bits;
- same-cycle visibility of input changes on reads;
- reads of zero at holes and misaligned offsets.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned CTRL_W  = 8;
  localparam int unsigned EN_HALF = CTRL_W / 2;

  localparam logic [ADDR_W-1:0] OFF_ROUTE = 8'h0C;
  localparam logic [3:0] BANK_TCTRL = 4'h4;
  localparam logic [3:0] BANK_MCTRL = 4'h5;
  localparam logic [3:0] BANK_ISRC  = 4'h6;
  localparam logic [3:0] BANK_FSRC  = 4'h7;

  typedef enum logic [2:0] {
    RG_NONE, RG_ROUTE, RG_TCTRL, RG_MCTRL, RG_ISRC, RG_FSRC
  } rgrp_e;

  typedef struct packed {
    rgrp_e      grp;
    logic [1:0] idx;
  } dec_t;

  function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a,
                                       input int unsigned ncores);
    dec_t d;
    d.grp = RG_NONE;
    d.idx = a[3:2];
    if (a[1:0] == 2'b00) begin
      if (a == OFF_ROUTE) d.grp = RG_ROUTE;
      else if (32'(a[3:2]) < ncores) begin
        case (a[7:4])
          BANK_TCTRL: d.grp = RG_TCTRL;
          BANK_MCTRL: d.grp = RG_MCTRL;
          BANK_ISRC:  d.grp = RG_ISRC;
          BANK_FSRC:  d.grp = RG_FSRC;
          default:    d.grp = RG_NONE;
        endcase
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/irq_router_dec.sv
module irq_router_dec
  import irq_router_pkg::*;
#(
  parameter int unsigned N_CORES = 4
) (
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_en_o,
  output logic              rd_en_o,
  output dec_t              dec_o
);
  always_comb begin
    dec_o   = decode_addr(addr_i, N_CORES);
    wr_en_o = sel_i & we_i & (dec_o.grp != RG_NONE);
    rd_en_o = sel_i & ~we_i & (dec_o.grp != RG_NONE);
  end
endmodule

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irq_router_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned RW      = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  dec_t                            dec_i,
  input  logic [CTRL_W-1:0]               wdata_i,
  output logic [RW-1:0]                   route_irq_o,
  output logic [RW-1:0]                   route_fiq_o,
  output logic [N_CORES-1:0][CTRL_W-1:0]  tctrl_o,
  output logic [N_CORES-1:0][CTRL_W-1:0]  mctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_irq_o <= '0;
      route_fiq_o <= '0;
      tctrl_o     <= '0;
      mctrl_o     <= '0;
    end else if (wr_en_i) begin
      case (dec_i.grp)
        RG_ROUTE: begin
          route_irq_o <= wdata_i[RW-1:0];
          route_fiq_o <= wdata_i[2*RW-1:RW];
        end
        RG_TCTRL: tctrl_o[dec_i.idx] <= wdata_i;
        RG_MCTRL: mctrl_o[dec_i.idx] <= wdata_i;
        default: ;
      endcase
    end
  end

  logic cfg_wr;
  assign cfg_wr = wr_en_i & (dec_i.grp inside {RG_ROUTE, RG_TCTRL, RG_MCTRL});

  // config only moves on a decoded config write (R3, R9)
  p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wr |=> ($stable(tctrl_o) && $stable(mctrl_o)
                 && $stable(route_irq_o) && $stable(route_fiq_o)));
endmodule

// File: rtl/irq_router_src.sv
module irq_router_src
  import irq_router_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned N_LOCAL = 4,
  parameter int unsigned N_MBOX  = 4,
  parameter int unsigned RW      = 2,
  localparam int unsigned UP_BIT = N_LOCAL + N_MBOX,
  localparam int unsigned SRC_W  = UP_BIT + 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_CORES*N_LOCAL-1:0]     tmr_i,
  input  logic [N_CORES*N_MBOX-1:0]      mbox_i,
  input  logic                           up_irq_i,
  input  logic                           up_fiq_i,
  input  logic [RW-1:0]                  route_irq_i,
  input  logic [RW-1:0]                  route_fiq_i,
  input  logic [N_CORES-1:0][CTRL_W-1:0] tctrl_i,
  input  logic [N_CORES-1:0][CTRL_W-1:0] mctrl_i,
  output logic [N_CORES-1:0][SRC_W-1:0]  irq_src_o,
  output logic [N_CORES-1:0][SRC_W-1:0]  fiq_src_o
);
  logic [N_CORES-1:0] up_irq_col, up_fiq_col;

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    for (genvar n = 0; n < N_LOCAL; n++) begin : g_tmr
      logic act;
      assign act = tmr_i[c*N_LOCAL+n];
      assign fiq_src_o[c][n] = act & tctrl_i[c][n+EN_HALF];
      assign irq_src_o[c][n] = act & tctrl_i[c][n] & ~tctrl_i[c][n+EN_HALF];
    end
    for (genvar j = 0; j < N_MBOX; j++) begin : g_mbx
      logic act;
      assign act = mbox_i[c*N_MBOX+j];
      assign fiq_src_o[c][N_LOCAL+j] = act & mctrl_i[c][j+EN_HALF];
      assign irq_src_o[c][N_LOCAL+j] = act & mctrl_i[c][j] & ~mctrl_i[c][j+EN_HALF];
    end
    assign irq_src_o[c][UP_BIT] = up_irq_i & (route_irq_i == RW'(c));
    assign fiq_src_o[c][UP_BIT] = up_fiq_i & (route_fiq_i == RW'(c));
    assign up_irq_col[c] = irq_src_o[c][UP_BIT];
    assign up_fiq_col[c] = fiq_src_o[c][UP_BIT];

    // a local source lands on at most one of IRQ/FIQ (R4, R5)
    p_fiq_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_src_o[c][UP_BIT-1:0] & fiq_src_o[c][UP_BIT-1:0]) == '0);
  end

  // upstream lines go to exactly one core (R6)
  p_up_irq_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(up_irq_col) == 32'(up_irq_i));
  p_up_fiq_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(up_fiq_col) == 32'(up_fiq_i));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned N_LOCAL = 4,
  parameter int unsigned N_MBOX  = 4,
  localparam int unsigned RW     = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int unsigned SRC_W  = N_LOCAL + N_MBOX + 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_CORES*N_LOCAL-1:0] tmr_irq_i,
  input  logic [N_CORES*N_MBOX-1:0]  mbox_pend_i,
  input  logic                       up_irq_i,
  input  logic                       up_fiq_i,
  input  logic                       bus_sel_i,
  input  logic                       bus_we_i,
  input  logic [ADDR_W-1:0]          bus_addr_i,
  input  logic [DATA_W-1:0]          bus_wdata_i,
  output logic [DATA_W-1:0]          bus_rdata_o,
  output logic [N_CORES-1:0]         irq_o,
  output logic [N_CORES-1:0]         fiq_o
);
  logic wr_en, rd_en;
  dec_t dec;
  logic [RW-1:0] route_irq, route_fiq;
  logic [N_CORES-1:0][CTRL_W-1:0] tctrl, mctrl;
  logic [N_CORES-1:0][SRC_W-1:0]  irq_src, fiq_src;
  logic [N_CORES-1:0] irq_any, fiq_any;

  irq_router_dec #(.N_CORES(N_CORES)) u_dec (
    .sel_i(bus_sel_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wr_en_o(wr_en), .rd_en_o(rd_en), .dec_o(dec)
  );

  irq_router_regs #(.N_CORES(N_CORES), .RW(RW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .dec_i(dec),
    .wdata_i(bus_wdata_i[CTRL_W-1:0]),
    .route_irq_o(route_irq), .route_fiq_o(route_fiq),
    .tctrl_o(tctrl), .mctrl_o(mctrl)
  );

  irq_router_src #(.N_CORES(N_CORES), .N_LOCAL(N_LOCAL), .N_MBOX(N_MBOX), .RW(RW)) u_src (
    .clk_i, .rst_ni, .tmr_i(tmr_irq_i), .mbox_i(mbox_pend_i),
    .up_irq_i, .up_fiq_i, .route_irq_i(route_irq), .route_fiq_i(route_fiq),
    .tctrl_i(tctrl), .mctrl_i(mctrl),
    .irq_src_o(irq_src), .fiq_src_o(fiq_src)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (rd_en) begin
      case (dec.grp)
        RG_ROUTE: bus_rdata_o = DATA_W'({route_fiq, route_irq});
        RG_TCTRL: bus_rdata_o = DATA_W'(tctrl[dec.idx]);
        RG_MCTRL: bus_rdata_o = DATA_W'(mctrl[dec.idx]);
        RG_ISRC:  bus_rdata_o = DATA_W'(irq_src[dec.idx]);
        RG_FSRC:  bus_rdata_o = DATA_W'(fiq_src[dec.idx]);
        default:  bus_rdata_o = '0;
      endcase
    end
  end

  for (genvar c = 0; c < N_CORES; c++) begin : g_any
    assign irq_any[c] = |irq_src[c];
    assign fiq_any[c] = |fiq_src[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= '0;
      fiq_o <= '0;
    end else begin
      irq_o <= irq_any;
      fiq_o <= fiq_any;
    end
  end

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_out_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (irq_o == $past(irq_any)) && (fiq_o == $past(fiq_any)));
endmodule

// File: tb/irq_router_tb.sv
module irq_router_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] tmr = '0, mbox = '0;
  logic up_irq = 1'b0, up_fiq = 1'b0;
  logic sel = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [3:0] irq_o, fiq_o;

  always #10 clk = ~clk;

  irq_router u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tmr_irq_i(tmr), .mbox_pend_i(mbox),
    .up_irq_i(up_irq), .up_fiq_i(up_fiq), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [1:0] sh_ri = '0, sh_rf = '0;
  logic [7:0] sh_t[4], sh_m[4];

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    sel = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    sel = 0; we = 0;
    if (a == 8'h0C) begin sh_ri = d[1:0]; sh_rf = d[3:2]; end
    else if (a[1:0] == 0 && a[7:4] == 4'h4) sh_t[a[3:2]] = d[7:0];
    else if (a[1:0] == 0 && a[7:4] == 4'h5) sh_m[a[3:2]] = d[7:0];
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1; we = 0; addr = a;
    #1 d = rdata;
    sel = 0;
  endtask

  function automatic logic [8:0] exp_src(int c, bit f);
    logic [8:0] r = '0;
    for (int n = 0; n < 4; n++) begin
      if (tmr[c*4+n]) begin
        if (sh_t[c][n+4]) r[n] = f;
        else if (sh_t[c][n]) r[n] = !f;
      end
      if (mbox[c*4+n]) begin
        if (sh_m[c][n+4]) r[4+n] = f;
        else if (sh_m[c][n]) r[4+n] = !f;
      end
    end
    r[8] = f ? (up_fiq && sh_rf == c) : (up_irq && sh_ri == c);
    return r;
  endfunction

  task automatic chk_all(string req);
    logic [31:0] d;
    logic [3:0] ei, ef;
    for (int c = 0; c < 4; c++) begin
      rd(8'h60 + 8'(4*c), d); chk({req, " isrc"}, d, {23'b0, exp_src(c, 0)});
      rd(8'h70 + 8'(4*c), d); chk({req, " fsrc"}, d, {23'b0, exp_src(c, 1)});
    end
    @(posedge clk); #1;
    for (int c = 0; c < 4; c++) begin
      ei[c] = |exp_src(c, 0);
      ef[c] = |exp_src(c, 1);
    end
    chk("R8 irq_o", {28'b0, irq_o}, {28'b0, ei});
    chk("R8 fiq_o", {28'b0, fiq_o}, {28'b0, ef});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    for (int c = 0; c < 4; c++) begin sh_t[c] = '0; sh_m[c] = '0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq_o in reset", {28'b0, irq_o}, 0);
    chk("R1 fiq_o in reset", {28'b0, fiq_o}, 0);
    @(negedge clk); rst_n = 1;
    rd(8'h0C, d); chk("R1 route", d, 0);
    for (int c = 0; c < 4; c++) begin
      rd(8'h40 + 8'(4*c), d); chk("R1 tctrl", d, 0);
      rd(8'h50 + 8'(4*c), d); chk("R1 mctrl", d, 0);
    end

    // R2 packing
    wr(8'h0C, 32'hFFFF_FFF9);
    rd(8'h0C, d); chk("R2 route pack", d, 32'h9);

    // R3 masking to 8 bits
    wr(8'h48, 32'h1234_56A5);
    rd(8'h48, d); chk("R3 tctrl mask", d, 32'hA5);
    wr(8'h54, 32'hFFFF_FF3C);
    rd(8'h54, d); chk("R3 mctrl mask", d, 32'h3C);

    // R4: src0 IRQ only, src1 FIQ only, src2 both, src3 none
    wr(8'h40, 32'h65);
    @(negedge clk); tmr = 16'h000F;
    rd(8'h60, d); chk("R4 isrc core0", d, 32'h001);
    rd(8'h70, d); chk("R4 fsrc core0", d, 32'h006);
    chk_all("R4");

    // R5: mailboxes on core 3
    wr(8'h5C, 32'h65);
    @(negedge clk); tmr = '0; mbox = 16'hF000;
    rd(8'h6C, d); chk("R5 isrc core3", d, 32'h010);
    rd(8'h7C, d); chk("R5 fsrc core3", d, 32'h060);
    chk_all("R5");

    // R6: upstream IRQ to core 1, FIQ to core 2
    @(negedge clk); mbox = '0; up_irq = 1; up_fiq = 1;
    rd(8'h64, d); chk("R6 irq on core1", d, 32'h100);
    rd(8'h60, d); chk("R6 irq not core0", d, 32'h000);
    rd(8'h78, d); chk("R6 fiq on core2", d, 32'h100);
    rd(8'h74, d); chk("R6 fiq not core1", d, 32'h000);
    wr(8'h0C, 32'hF);
    chk_all("R6 both to core3");

    // R7: same-cycle visibility and read-only source regs
    wr(8'h4C, 32'h0F);
    @(negedge clk);
    up_irq = 0; up_fiq = 0; tmr = 16'h2000;
    sel = 1; we = 0; addr = 8'h6C;
    #1 chk("R7 same cycle", rdata, 32'h002);
    chk("R8 not yet", {28'b0, irq_o}, 32'h8);
    sel = 0;
    @(posedge clk); #1;
    chk("R8 after edge", {28'b0, irq_o}, 32'h8);
    @(negedge clk); tmr = '0;
    @(posedge clk); #1;
    chk("R8 drops", {28'b0, irq_o}, 32'h0);
    wr(8'h6C, 32'hFFFF_FFFF);
    @(negedge clk); tmr = 16'h2000;
    rd(8'h6C, d); chk("R7 write ignored", d, 32'h002);

    // R9: unmapped and misaligned
    wr(8'h10, 32'hFF); wr(8'h42, 32'hFF); wr(8'h80, 32'hFF); wr(8'h0D, 32'hFF);
    rd(8'h40, d); chk("R9 tctrl0 kept", d, 32'h65);
    rd(8'h0C, d); chk("R9 route kept", d, 32'hF);
    rd(8'h42, d); chk("R9 misaligned read", d, 0);
    rd(8'h90, d); chk("R9 hole read", d, 0);
    rd(8'h0D, d); chk("R9 misaligned route", d, 0);

    // random mix covering R4..R8
    for (int it = 0; it < 300; it++) begin
      int k;
      k = int'($urandom_range(0, 3));
      for (int w = 0; w < k; w++) begin
        int g;
        g = int'($urandom_range(0, 2));
        if (g == 0) wr(8'h0C, $urandom);
        else wr((g == 1 ? 8'h40 : 8'h50) + 8'(4 * $urandom_range(0, 3)), $urandom);
      end
      @(negedge clk);
      tmr = 16'($urandom); mbox = 16'($urandom);
      up_irq = 1'($urandom); up_fiq = 1'($urandom);
      chk_all("R4 R5 R6 R7 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule